// File: doc/BRIEF.md
# Time-Hopping Code Phase Finder

This block resolves which phase of a time-hopping code a pulse stream is using, once chip-level timing is already locked. A bit spans `NF` frames of `NC` chips. In each frame the transmitter places one pulse, at an in-frame chip position taken from a code table. The block takes one correlator sample per chip strobe and compares it with a threshold. It credits each detected pulse to every candidate code phase that predicts a pulse in that chip. After exactly one bit period it reports the candidate with the largest tally.

The block does not run one correlator per phase. It keeps one small counter per candidate slot. Slots are armed only by the first detected pulse, and only for the phases that agree with it. Every candidate is scored in parallel during a single bit period. When nothing credible is seen, the block raises a failure flag and reports no phase.

Top module: `th_phase_search`

## Requirements
- R1: After reset, `done` and `fail` are 0 and `phase` is 0.
- R2: A `start` pulse clears all slots and counts and drops `done`. The search then begins at chip position 0 of frame 0.
- R3: A chip counts as a pulse only when `corr` is strictly greater than `thr`. A sample equal to the threshold is not a pulse.
- R4: The code value for frame f sits in `th_code[f*CBW +: CBW]`. Candidate phase p expects a pulse in frame f at in-frame chip `th_code` entry `(f+p) mod NF`. The first detected pulse arms exactly the slots whose phase expects it, and gives each of them a count of 1. Slots that are not armed keep a count of 0.
- R5: Each later detected pulse adds 1 to every armed slot that expects a pulse in that chip. No other slot changes, and counts never change without a strobe.
- R6: `done` rises in the cycle after the `NF*NC`-th chip strobe of a search. It is not raised earlier, and it stays high until the next `start`.
- R7: When a search succeeds, `phase` is the armed slot with the highest count. On a tie, the lowest slot index wins.
- R8: `fail` is high with `done` when no slot was armed, either because no pulse was seen or because the first pulse matched no phase. `phase` then reads 0.
- R9: Chip strobes given while no search is running change nothing.
- R10: A `start` during a search abandons it and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new phase search |
| chip_stb | input | 1 | One pulse per chip, marks `corr` valid |
| corr | input | SW | Correlator sample for the current chip |
| thr | input | SW | Pulse detection threshold |
| th_code | input | NF*CBW | Hopping code, one in-frame chip position per frame |
| phase | output | PW | Winning code phase |
| done | output | 1 | Search finished |
| fail | output | 1 | Search finished without a candidate |

## Verification
On every cycle, the assertions check several properties. Unarmed slots stay at zero, and counts move only on strobes and never by more than one. `done` follows the last chip strobe and is cleared by `start`. A reported winner is always an armed slot.

Only the bench scenarios can show that the right slots are armed and credited for a given code table and pulse pattern. They also show that ties resolve to the lowest slot, that equal-to-threshold samples are ignored, and that an unmatched first pulse ends in failure.

// File: rtl/th_phase_search.sv
module th_phase_search #(
  parameter int NF = 4,
  parameter int NC = 8,
  parameter int SW = 12,
  localparam int CBW = (NC > 1) ? $clog2(NC) : 1,
  localparam int FBW = (NF > 1) ? $clog2(NF) : 1,
  localparam int PW  = FBW,
  localparam int KW  = $clog2(NF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chip_stb,
  input  logic [SW-1:0]     corr,
  input  logic [SW-1:0]     thr,
  input  logic [NF*CBW-1:0] th_code,
  output logic [PW-1:0]     phase,
  output logic              done,
  output logic              fail
);

  logic           active, seen;
  logic [FBW-1:0] frm;
  logic [CBW-1:0] pos;
  logic [NF-1:0]  valid, exp_v;
  logic [KW-1:0]  cnt [NF];
  logic           hit, last, any;
  logic [PW-1:0]  best;
  logic [KW-1:0]  bestc;

  assign hit  = corr > thr;
  assign last = (pos == CBW'(NC - 1)) && (frm == FBW'(NF - 1));

  for (genvar p = 0; p < NF; p++) begin : g_exp
    logic [FBW:0] idx;
    always_comb begin
      idx = {1'b0, frm} + (FBW+1)'(p);
      if (idx >= (FBW+1)'(NF)) idx = idx - (FBW+1)'(NF);
      exp_v[p] = th_code[idx*CBW +: CBW] == pos;
    end
  end

  always_comb begin
    best  = '0;
    bestc = '0;
    any   = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (valid[i] && (!any || cnt[i] > bestc)) begin
        any   = 1'b1;
        best  = PW'(i);
        bestc = cnt[i];
      end
    end
  end

  assign phase = best;
  assign fail  = done && !any;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      active <= start;
      seen   <= 1'b0;
      done   <= 1'b0;
      frm    <= '0;
      pos    <= '0;
      valid  <= '0;
      for (int i = 0; i < NF; i++) cnt[i] <= '0;
    end else if (active && chip_stb) begin
      if (hit) begin
        if (!seen) begin
          seen  <= 1'b1;
          valid <= exp_v;
          for (int i = 0; i < NF; i++) cnt[i] <= exp_v[i] ? KW'(1) : '0;
        end else begin
          for (int i = 0; i < NF; i++)
            if (valid[i] && exp_v[i]) cnt[i] <= cnt[i] + KW'(1);
        end
      end
      if (pos == CBW'(NC - 1)) begin
        pos <= '0;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          frm <= frm + FBW'(1);
        end
      end else begin
        pos <= pos + CBW'(1);
      end
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    // R4
    unarmed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid[i] |-> cnt[i] == '0);
    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_stb && !start) |=> $stable(cnt[i]));
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + KW'(1)));
  end

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && chip_stb && !start && last) |=> done);
  // R2
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  // R7
  win_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> valid[phase]);

endmodule

// File: tb/tb_th_phase_search.sv
`timescale 1ns/1ps
module tb_th_phase_search;
  localparam int NF = 4, NC = 8, SW = 12, NV = 7;
  localparam logic [SW-1:0] THR = 12'd100;

  localparam logic [11:0] V_CODE [NV] = '{12'hC6B, 12'hC6B, 12'hC6B, 12'hC6B, 12'h552, 12'h552, 12'h552};
  localparam logic [31:0] V_MASK [NV] = '{32'h40022008, 32'h20084002, 32'h0, 32'h40022009,
                                          32'h00000004, 32'h00002004, 32'h20040004};
  localparam logic        V_FAIL [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0]  V_PH   [NV] = '{2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 2'd3};

  logic clk = 0, rst_n = 0, start = 0, chip_stb = 0;
  logic [SW-1:0] corr = '0, thr = THR;
  logic [11:0] th_code = '0;
  logic [1:0] phase;
  logic done, fail;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  th_phase_search #(.NF(NF), .NC(NC), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_stb(chip_stb), .corr(corr),
    .thr(thr), .th_code(th_code), .phase(phase), .done(done), .fail(fail));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic feed(logic [31:0] mask, int amp, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      corr = mask[k] ? THR + SW'(amp) : THR - SW'(k % 7);
      chip_stb = 1;
      @(negedge clk) chip_stb = 0;
      for (int g = 0; g < k % 3; g++) @(negedge clk);
    end
  endtask

  task automatic search(logic [11:0] code, logic [31:0] mask, int amp);
    th_code = code;
    kick();
    feed(mask, amp, 31);
    chk("R6 early done", done, 0);
    feed(mask >> 31, amp, 1);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 phase", phase, 0);
    rst_n = 1;
    th_code = 12'hC6B;
    feed(32'hFFFFFFFF, 5, 40);
    chk("R9 idle strobes done", done, 0);

    for (int v = 0; v < NV; v++) begin
      search(V_CODE[v], V_MASK[v], 20);
      chk($sformatf("R6 done v%0d", v), done, 1);
      chk($sformatf("R8 fail v%0d", v), fail, V_FAIL[v]);
      chk($sformatf("R7 R4 R5 phase v%0d", v), phase, V_PH[v]);
    end

    feed(32'hFFFFFFFF, 5, 40);
    chk("R9 after done, done", done, 1);
    chk("R9 after done, phase", phase, 3);
    chk("R9 after done, fail", fail, 0);

    search(12'hC6B, 32'h40022008, 0);
    chk("R3 equal threshold fail", fail, 1);
    chk("R3 equal threshold done", done, 1);
    search(12'hC6B, 32'h40022008, 1);
    chk("R3 one above threshold", phase, 0);
    chk("R3 one above fail", fail, 0);

    th_code = 12'hC6B;
    kick();
    chk("R2 start clears done", done, 0);
    feed(32'h20084002, 20, 15);
    search(12'hC6B, 32'h40022008, 20);
    chk("R10 restart phase", phase, 0);
    chk("R10 restart fail", fail, 0);
    repeat (5) @(negedge clk);
    chk("R6 done held", done, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule